// File: doc/BRIEF.md
# Multi-hit quadrature-clock TDC

This block timestamps the rising edges of a bank of discriminator outputs during a gated acquisition window. A coarse counter runs on the 100 MHz reference clock. A second clock input at the same frequency, delayed by a quarter period, provides the fine time. Each input is sampled on both edges of both clocks. That gives four phase samples per 10 ns slot and a least count of 2.5 ns, with no faster clock needed. The four samples are brought into the reference-clock domain through two-flop synchronizers. For each hit, a 2-bit fine code is taken from the first phase sample that sees the input high.

A level gate input opens a window on its rising edge and closes it when it is seen low. The coarse count restarts at zero on the opening edge. Each channel keeps at most four timestamps per window; later hits set that channel's overflow bit. Once the window closes, the block is busy while it copies every channel's count, overflow bit and timestamps into an on-board RAM. The readout side fetches these words with an address and a read strobe, and has the whole time until the next window to do so. A gate edge that arrives while the block is busy is dropped and tallied.

Top module: `qtdc_bank`

## Requirements
- R1: While reset is held low, gate_open, busy and ign_cnt are all zero.
- R2: When gate_in is sampled high after being sampled low and the block is idle, gate_open rises after that edge. It falls after the first edge at which gate_in is sampled low.
- R3: Each stored timestamp is {coarse, fine}. Coarse (bits 13:2) is the number of slots between the opening edge and the hit's slot. The slot starting at the opening edge is slot 0. Fine (bits 1:0) is the first phase sample that saw the input high: 0 for the 0° rising edge, 1 for the 90° rising edge, 2 for the 0° falling edge, 3 for the 90° falling edge.
- R4: A hit is recorded only when the 90° falling-edge sample of the previous slot was low. An input held high across many slots is stored once.
- R5: Only hits whose slot lies from the opening edge up to the slot before the closing edge are stored.
- R6: A channel stores at most four timestamps per window. Each further hit is dropped and sets that channel's overflow bit.
- R7: busy is high for exactly N_CH*(HITS+1)+2 cycles after the closing edge, and is never high together with gate_open.
- R8: A rising edge of gate_in seen while busy does not open a window, and increments ign_cnt by one.
- R9: RAM address {channel, word}, with a 3-bit word index, holds: in word 0, the hit count in bits 2:0 and the overflow bit in bit 3; in words 1 to 4, the timestamps in arrival order. rd_data shows the addressed word in the cycle after rd_en.
- R10: Opening a window clears every channel's count and overflow bit left from the previous window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0 | input | 1 | 100 MHz reference clock, 0° phase |
| clk90 | input | 1 | Same frequency, delayed by 90° |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_in | input | 1 | Acquisition window request, level |
| disc | input | N_CH | Discriminator outputs, one per channel |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address {channel, word} |
| rd_data | output | CW+2 | Read word, valid one cycle after rd_en |
| gate_open | output | 1 | Window is open |
| busy | output | 1 | Draining and copying to RAM |
| ign_cnt | output | IGN_W | Count of gate edges dropped while busy |

## Verification
Two events can meet in one cycle. The first is the last cycle of the copy to RAM. The second is a new gate edge, which must still be dropped and counted. The bench provokes this by raising gate_in so that it is sampled exactly at the edge where busy falls. It then holds gate_in high and expects the window to stay closed until gate_in drops and rises again. A behavioural model of the gate, busy and drop counter is compared on every clock. Hits are placed on the slot just before the closing edge and on the closing slot itself, including a fine code 0 rise that moves into the next slot, so that commit and close meet at the window boundary.

// File: rtl/qtdc_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the quadrature-clock TDC.
package qtdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_COPY  = 2'd3
    } tdc_state_t;

    // Index of the earliest phase sample that is high (bit 0 earliest).
    function automatic logic [1:0] first_phase(input logic [3:0] v);
        if (v[0])      return 2'd0;
        else if (v[1]) return 2'd1;
        else if (v[2]) return 2'd2;
        else           return 2'd3;
    endfunction
endpackage

// File: rtl/qtdc_phase_sampler.sv
`timescale 1ns/1ps
// Samples one discriminator input on four clock phases and brings the four
// samples of each 10 ns slot into the clk0 domain through two flop stages.
// Assumes clk90 is clk0 delayed by a quarter period. Output bit 0 is the
// 0-degree rising sample; bit 3 is the 90-degree falling sample.
module qtdc_phase_sampler (
    input  logic       clk0,
    input  logic       clk90,
    input  logic       rst_n,
    input  logic       din,
    output logic [3:0] slot_v
);
    logic smp_r0, smp_r90, smp_f0, smp_f90;
    logic [3:0] sync_a, sync_b;

    // Phase sample on the 0-degree rising edge.
    always_ff @(posedge clk0) begin
        if (!rst_n) smp_r0 <= 1'b0;
        else        smp_r0 <= din;
    end

    // Phase sample on the 90-degree rising edge.
    always_ff @(posedge clk90) begin
        if (!rst_n) smp_r90 <= 1'b0;
        else        smp_r90 <= din;
    end

    // Phase sample on the 0-degree falling edge.
    always_ff @(negedge clk0) begin
        if (!rst_n) smp_f0 <= 1'b0;
        else        smp_f0 <= din;
    end

    // Phase sample on the 90-degree falling edge.
    always_ff @(negedge clk90) begin
        if (!rst_n) smp_f90 <= 1'b0;
        else        smp_f90 <= din;
    end

    // Two-stage transfer of the slot's four samples into clk0.
    always_ff @(posedge clk0) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
        end else begin
            sync_a <= {smp_f90, smp_f0, smp_r90, smp_r0};
            sync_b <= sync_a;
        end
    end

    assign slot_v = sync_b;
endmodule

// File: rtl/qtdc_hit_store.sv
`timescale 1ns/1ps
// Per-channel hit detector and timestamp store. A hit is a slot with any
// high sample whose preceding 90-degree falling sample was low. Up to HITS
// timestamps are kept per window; extra hits set the overflow bit.
// Assumes win and coarse are aligned with slot_v by the controller.
module qtdc_hit_store #(
    parameter int HITS   = 4,
    parameter int CW     = 12,
    parameter int TS_W   = CW + 2,
    parameter int CNT_W  = $clog2(HITS + 1),
    parameter int WSEL_W = $clog2(HITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        slot_v,
    input  logic              win,
    input  logic              clr,
    input  logic [CW-1:0]     coarse,
    input  logic [WSEL_W-1:0] word_sel,
    output logic [TS_W-1:0]   word_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic              ovf_out
);
    import qtdc_pkg::*;
    localparam int IDX_W = (HITS > 1) ? $clog2(HITS) : 1;

    logic              last_f90;
    logic [CNT_W-1:0]  cnt;
    logic              ovf;
    logic [TS_W-1:0]   ts [HITS];
    logic              hit;

    assign hit = !last_f90 && (|slot_v);

    // Remember the last sample of each slot for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_f90 <= 1'b0;
        else        last_f90 <= slot_v[3];
    end

    // Hit count and overflow, cleared when a window opens.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (win && hit) begin
            if (cnt == CNT_W'(HITS)) ovf <= 1'b1;
            else                     cnt <= cnt + 1'b1;
        end
    end

    // Timestamp write into the next free entry.
    always_ff @(posedge clk) begin
        if (rst_n && !clr && win && hit && (cnt != CNT_W'(HITS)))
            ts[cnt[IDX_W-1:0]] <= {coarse, first_phase(slot_v)};
    end

    // Word selection for the copy into RAM.
    always_comb begin
        word_out = '0;
        if (word_sel == '0) begin
            word_out[CNT_W:0] = {ovf, cnt};
        end else begin
            for (int i = 0; i < HITS; i++)
                if (word_sel == WSEL_W'(i + 1)) word_out = ts[i];
        end
    end

    assign cnt_out = cnt;
    assign ovf_out = ovf;
endmodule

// File: rtl/qtdc_ctrl.sv
`timescale 1ns/1ps
// Window controller: opens on a gate rising edge while idle, closes when the
// gate is low, drains the two-stage sample pipeline, then steps through every
// channel word for the RAM copy. Drops and counts gate edges seen while busy.
module qtdc_ctrl #(
    parameter int N_CH   = 4,
    parameter int HITS   = 4,
    parameter int CW     = 12,
    parameter int IGN_W  = 8,
    parameter int CH_W   = $clog2(N_CH),
    parameter int WSEL_W = $clog2(HITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_in,
    output logic              gate_open,
    output logic              busy,
    output logic [IGN_W-1:0]  ign_cnt,
    output logic              win,
    output logic              clr,
    output logic [CW-1:0]     coarse,
    output logic              copy_we,
    output logic [CH_W-1:0]   copy_ch,
    output logic [WSEL_W-1:0] copy_w
);
    import qtdc_pkg::*;

    tdc_state_t state;
    logic gate_prev, acq_d1, acq_d2, drain_cnt, rise, copy_last;

    assign rise      = gate_in && !gate_prev;
    assign clr       = (state == ST_IDLE) && rise;
    assign busy      = (state == ST_DRAIN) || (state == ST_COPY);
    assign gate_open = (state == ST_ACQ);
    assign copy_we   = (state == ST_COPY);
    assign win       = acq_d2;
    assign copy_last = (copy_ch == CH_W'(N_CH - 1)) && (copy_w == WSEL_W'(HITS));

    // Gate history and window flag delayed to match the sample pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_prev <= 1'b0;
            acq_d1    <= 1'b0;
            acq_d2    <= 1'b0;
        end else begin
            gate_prev <= gate_in;
            acq_d1    <= (state == ST_ACQ);
            acq_d2    <= acq_d1;
        end
    end

    // Coarse slot count, zero in the slot of the opening edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !acq_d2) coarse <= '0;
        else                   coarse <= coarse + 1'b1;
    end

    // Window, drain and copy sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            drain_cnt <= 1'b0;
            copy_ch   <= '0;
            copy_w    <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (rise) state <= ST_ACQ;
                ST_ACQ:   if (!gate_in) begin
                              state     <= ST_DRAIN;
                              drain_cnt <= 1'b0;
                          end
                ST_DRAIN: if (drain_cnt) begin
                              state   <= ST_COPY;
                              copy_ch <= '0;
                              copy_w  <= '0;
                          end else begin
                              drain_cnt <= 1'b1;
                          end
                ST_COPY:  if (copy_last) begin
                              state <= ST_IDLE;
                          end else if (copy_w == WSEL_W'(HITS)) begin
                              copy_w  <= '0;
                              copy_ch <= copy_ch + 1'b1;
                          end else begin
                              copy_w <= copy_w + 1'b1;
                          end
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Tally of gate edges dropped while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)           ign_cnt <= '0;
        else if (rise && busy) ign_cnt <= ign_cnt + 1'b1;
    end
endmodule

// File: rtl/qtdc_bank.sv
`timescale 1ns/1ps
// Bank of quadrature-clock TDC channels with a shared window controller and a
// result RAM read through an address/strobe port with one cycle of latency.
// Assumes clk90 is clk0 delayed by 90 degrees and gate_in is clk0-synchronous.
module qtdc_bank #(
    parameter int N_CH  = 4,
    parameter int HITS  = 4,
    parameter int CW    = 12,
    parameter int IGN_W = 8,
    localparam int TS_W   = CW + 2,
    localparam int CNT_W  = $clog2(HITS + 1),
    localparam int WSEL_W = $clog2(HITS + 1),
    localparam int CH_W   = $clog2(N_CH),
    localparam int ADDR_W = CH_W + WSEL_W
) (
    input  logic              clk0,
    input  logic              clk90,
    input  logic              rst_n,
    input  logic              gate_in,
    input  logic [N_CH-1:0]   disc,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [TS_W-1:0]   rd_data,
    output logic              gate_open,
    output logic              busy,
    output logic [IGN_W-1:0]  ign_cnt
);
    localparam int DEPTH = 1 << ADDR_W;

    logic              win, clr, copy_we;
    logic [CW-1:0]     coarse;
    logic [CH_W-1:0]   copy_ch;
    logic [WSEL_W-1:0] copy_w;
    logic [TS_W-1:0]   ch_word [N_CH];
    logic [N_CH*CNT_W-1:0] cnt_flat;
    logic [N_CH-1:0]   ovf_flat;
    logic [TS_W-1:0]   ram [DEPTH];

    qtdc_ctrl #(.N_CH(N_CH), .HITS(HITS), .CW(CW), .IGN_W(IGN_W),
                .CH_W(CH_W), .WSEL_W(WSEL_W)) u_ctrl (
        .clk(clk0), .rst_n(rst_n), .gate_in(gate_in),
        .gate_open(gate_open), .busy(busy), .ign_cnt(ign_cnt),
        .win(win), .clr(clr), .coarse(coarse),
        .copy_we(copy_we), .copy_ch(copy_ch), .copy_w(copy_w)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [3:0]       slot_v;
        logic [CNT_W-1:0] cnt_c;

        qtdc_phase_sampler u_smp (
            .clk0(clk0), .clk90(clk90), .rst_n(rst_n),
            .din(disc[c]), .slot_v(slot_v)
        );

        qtdc_hit_store #(.HITS(HITS), .CW(CW), .TS_W(TS_W),
                         .CNT_W(CNT_W), .WSEL_W(WSEL_W)) u_store (
            .clk(clk0), .rst_n(rst_n), .slot_v(slot_v), .win(win),
            .clr(clr), .coarse(coarse), .word_sel(copy_w),
            .word_out(ch_word[c]), .cnt_out(cnt_c), .ovf_out(ovf_flat[c])
        );

        assign cnt_flat[c*CNT_W +: CNT_W] = cnt_c;
    end

    // Copy of the selected channel word into the result RAM.
    always_ff @(posedge clk0) begin
        if (copy_we) ram[{copy_ch, copy_w}] <= ch_word[copy_ch];
    end

    // Registered read port.
    always_ff @(posedge clk0) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= ram[rd_addr];
    end
endmodule

// Temporal checks on the window controller and per-channel stores.
module qtdc_bank_chk #(
    parameter int N_CH  = 4,
    parameter int HITS  = 4,
    parameter int CNT_W = 3,
    parameter int IGN_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  gate_in,
    input logic                  gate_open,
    input logic                  busy,
    input logic [IGN_W-1:0]      ign_cnt,
    input logic                  win,
    input logic                  clr,
    input logic [N_CH*CNT_W-1:0] cnt_flat,
    input logic [N_CH-1:0]       ovf_flat
);
    assert_open_needs_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> $past(gate_in));

    assert_busy_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && gate_open));

    assert_busy_after_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(gate_open));

    assert_drop_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && gate_in && !$past(gate_in)) |=> !gate_open);

    assert_ign_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ign_cnt == $past(ign_cnt)) || (ign_cnt == IGN_W'($past(ign_cnt) + 1'b1)));

    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        assert_cnt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_flat[c*CNT_W +: CNT_W] <= CNT_W'(HITS));

        assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_flat[c] && !clr) |=> ovf_flat[c]);

        assert_cnt_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_flat[c*CNT_W +: CNT_W] != $past(cnt_flat[c*CNT_W +: CNT_W]))
                |-> ($past(win) || $past(clr)));
    end
endmodule

bind qtdc_bank qtdc_bank_chk #(.N_CH(N_CH), .HITS(HITS), .CNT_W(CNT_W), .IGN_W(IGN_W)) u_chk (
    .clk(clk0), .rst_n(rst_n), .gate_in(gate_in), .gate_open(gate_open),
    .busy(busy), .ign_cnt(ign_cnt), .win(win), .clr(clr),
    .cnt_flat(cnt_flat), .ovf_flat(ovf_flat)
);

// File: tb/tb_qtdc_bank.sv
`timescale 1ns/1ps
module tb_qtdc_bank;
    localparam int N_CH = 4;
    localparam int HITS = 4;
    localparam int W    = N_CH * (HITS + 1);

    logic        clk0 = 1'b0;
    logic        clk90 = 1'b0;
    logic        rst_n = 1'b0;
    logic        gate_in = 1'b0;
    logic [3:0]  disc = '0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [13:0] rd_data;
    logic        gate_open, busy;
    logic [7:0]  ign_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural model state: 0 idle, 1 open, 2 busy.
    int m_state = 0;
    int m_rem = 0;
    int m_ign = 0;
    int mg = 0;
    int mc = 0;
    bit m_prev = 1'b0;
    int q_slot [N_CH][$];
    int q_fine [N_CH][$];

    qtdc_bank dut (
        .clk0(clk0), .clk90(clk90), .rst_n(rst_n), .gate_in(gate_in),
        .disc(disc), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .gate_open(gate_open), .busy(busy), .ign_cnt(ign_cnt)
    );

    initial forever #5 clk0 = ~clk0;
    initial begin
        #2.5;
        forever #5 clk90 = ~clk90;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Window, busy and drop-count model, stepped on every reference edge.
    always @(posedge clk0) begin
        int m;
        m = int'(($realtime - 5.0) / 10.0);
        if (!rst_n) begin
            m_state = 0; m_ign = 0; m_prev = 1'b0;
        end else begin
            if (m_state == 0) begin
                if (gate_in && !m_prev) begin m_state = 1; mg = m; end
            end else if (m_state == 1) begin
                if (!gate_in) begin m_state = 2; mc = m; m_rem = W + 2; end
            end else begin
                if (gate_in && !m_prev) m_ign++;
                if (m_rem == 1) m_state = 0;
                else            m_rem--;
            end
            m_prev = gate_in;
        end
    end

    // Compare the model with the outputs on every clock.
    always @(negedge clk0) begin
        if (!done) begin
            if (!rst_n) begin
                chk(!gate_open && !busy && ign_cnt == 0, "R1", {gate_open, busy}, 0);
            end else begin
                chk(gate_open == (m_state == 1), "R2", gate_open, m_state == 1);
                chk(busy == (m_state == 2), "R7", busy, m_state == 2);
                chk(ign_cnt == 8'(m_ign), "R8", ign_cnt, m_ign);
            end
        end
    end

    task automatic pulse(input int ch, input int f, input int w);
        real off;
        off = (f == 0) ? 8.5 : (f == 1) ? 1.0 : (f == 2) ? 3.5 : 6.0;
        #(off);
        disc[ch] = 1'b1;
        #(w);
        disc[ch] = 1'b0;
    endtask

    // Launch a rising edge that hits phase f; call right after a clk0 rise.
    task automatic fire(input int ch, input int f, input int w);
        int m;
        m = int'(($realtime - 5.0) / 10.0);
        q_slot[ch].push_back((f == 0) ? m + 1 : m);
        q_fine[ch].push_back(f);
        fork
            pulse(ch, f, w);
        join_none
    endtask

    task automatic rd_word(input int addr, output int val);
        @(negedge clk0);
        rd_en = 1'b1;
        rd_addr = 5'(addr);
        @(negedge clk0);
        rd_en = 1'b0;
        val = int'(rd_data);
    endtask

    // Read every channel and compare with hits expected inside [mg, mc).
    task automatic check_window(input string st_tag [N_CH]);
        for (int ch = 0; ch < N_CH; ch++) begin
            int n = 0;
            int ov = 0;
            int es [HITS];
            int v;
            for (int i = 0; i < q_slot[ch].size(); i++) begin
                if (q_slot[ch][i] >= mg && q_slot[ch][i] < mc) begin
                    if (n < HITS) begin
                        es[n] = (((q_slot[ch][i] - mg) & 12'hFFF) << 2) | q_fine[ch][i];
                        n++;
                    end else ov = 1;
                end
            end
            rd_word(ch * 8, v);
            chk(v == ((ov << 3) | n), st_tag[ch], v, (ov << 3) | n);
            for (int i = 0; i < n; i++) begin
                rd_word(ch * 8 + 1 + i, v);
                chk(v == es[i], "R3", v, es[i]);
            end
            q_slot[ch].delete();
            q_fine[ch].delete();
        end
    endtask

    initial begin
        string tags1 [N_CH];
        string tags2 [N_CH];
        tags1 = '{"R9", "R6", "R4", "R5"};
        tags2 = '{"R10", "R10", "R10", "R10"};
        repeat (5) @(negedge clk0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk0);

        // Window 1: mixed phases, overflow, long pulse, boundary slots.
        @(posedge clk0);
        fire(3, 1, 12);
        @(negedge clk0);
        gate_in = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(posedge clk0);
            case (k)
                0:  begin fire(0, 1, 12); fire(1, 2, 12); end
                2:  fire(2, 3, 100);
                4:  begin fire(0, 2, 12); fire(1, 0, 12); end
                5:  fire(3, 0, 12);
                8:  begin fire(0, 3, 12); fire(1, 1, 12); end
                12: begin fire(0, 0, 12); fire(1, 3, 12); end
                16: fire(1, 2, 12);
                20: fire(1, 1, 12);
                28: begin fire(3, 3, 12); fire(0, 0, 12); end
                29: fire(2, 1, 12);
                default: ;
            endcase
            if (k == 28) begin
                @(negedge clk0);
                gate_in = 1'b0;
            end
        end
        // Gate request in mid-copy, then one on the last busy edge.
        repeat (4) @(negedge clk0);
        gate_in = 1'b1;
        repeat (2) @(negedge clk0);
        gate_in = 1'b0;
        while (!(m_state == 2 && m_rem == 1)) @(negedge clk0);
        gate_in = 1'b1;
        repeat (3) @(negedge clk0);
        chk(gate_open == 1'b0, "R8", gate_open, 0);
        gate_in = 1'b0;
        repeat (2) @(negedge clk0);
        chk(ign_cnt == 8'd2, "R8", ign_cnt, 2);
        check_window(tags1);

        // Window 2: one hit; stale counts and overflow must be gone.
        @(negedge clk0);
        gate_in = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk0);
            if (k == 3) fire(1, 2, 12);
            if (k == 9) begin
                @(negedge clk0);
                gate_in = 1'b0;
            end
        end
        @(negedge clk0);
        while (m_state != 0) @(negedge clk0);
        check_window(tags2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule